// File: doc/BRIEF.md
# Fifteen-Level Prioritized Interrupt Controller

This block gathers interrupt requests on levels 1 through 15 and tells the processor which level to serve next. Each source gives a one-cycle pulse on its own request bit, which latches into a pending register. The pending bits, together with the bits of a force register when test mode is on, are filtered by a mask. The highest surviving level is presented as a registered 4-bit request level, where 0 means no request.

Software uses one write port and one read port. The write port carries a 2-bit register select. Through it software loads the mask, clears pending bits by writing ones, loads the force register and sets the test-mode enable. When the processor takes an interrupt, it reports the serviced level on the acknowledge input. In test mode, a forced bit at that level is removed first. Otherwise the pending bit is removed.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the pending, mask, force and control registers read as zero and `irl_o` is 0.
- R2: A request pulse on `req_i` bit n (1 to 15) sets pending bit n. Bit 0 of `req_i` is ignored, and pending bit 0 always reads 0.
- R3: `irl_o` is the highest set bit among levels 15 down to 1 of (pending OR force-when-test-mode) AND NOT mask. It is 0 when no such bit is set.
- R4: A write with select 0 (mask) stores only data bits [14:1]. Mask bits 15 and 0 always read 0, so level 15 cannot be masked.
- R5: A write with select 1 (clear) clears each pending bit whose data bit is 1 and leaves the other pending bits unchanged.
- R6: A write with select 2 (force) stores data bits [15:1] only while the test-mode bit is already set. Otherwise the write leaves the force register unchanged.
- R7: Force bits contribute to `irl_o` only while the test-mode bit (control bit 0, written with select 3) is set. Clearing the test-mode bit keeps the force contents.
- R8: In test mode, an acknowledge of level n clears force bit n if it is set and leaves pending bit n unchanged. If force bit n is clear, the acknowledge clears pending bit n.
- R9: Outside test mode, an acknowledge of level n clears pending bit n and leaves the force register unchanged.
- R10: When a request pulse for level n arrives in the same cycle as an acknowledge of level n, or as a clear write with bit n set, pending bit n ends set.
- R11: `irl_o` is registered and reflects a request, write or acknowledge at the first rising edge that samples it.
- R12: The read port returns mask for select 0, pending for select 1, force for select 2 and the control register (bit 0 = test mode) for select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 16 | One-cycle request pulse per level; bit 0 ignored |
| ack_i | input | 1 | Acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 clear, 2 force, 3 control |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Read source: 0 mask, 1 pending, 2 force, 3 control |
| rd_data_o | output | 16 | Combinational read data |
| irl_o | output | 4 | Registered highest active level |

## Verification
A request, write or acknowledge presented before a rising edge changes the registers and `irl_o` at that edge. Read data follows the registers combinationally, with no added cycle. The bench drives every input just after a falling edge and holds it for exactly one rising edge. It then checks `irl_o` and the read port at the next falling edge, which is one cycle after the stimulus. The same-cycle cases, a request arriving with an acknowledge or with a clear write, are presented within a single drive window so that both land on the same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      SEL_MASK  = 2'd0,
      SEL_CLEAR = 2'd1,
      SEL_FORCE = 2'd2,
      SEL_CTRL  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irqc_level_regs.sv
module irqc_level_regs
   import irqc_pkg::*;
#(
   parameter int VEC_W          = 16,
   parameter int LVL_W          = 4,
   parameter bit TOP_UNMASKABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] req_i,
   input  logic             ack_i,
   input  logic [LVL_W-1:0] ack_level_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [VEC_W-1:0] wr_data_i,
   output logic [VEC_W-1:0] pend_q,
   output logic [VEC_W-1:0] mask_q,
   output logic [VEC_W-1:0] force_q,
   output logic             test_q,
   output logic [VEC_W-1:0] pend_d,
   output logic [VEC_W-1:0] mask_d,
   output logic [VEC_W-1:0] force_d
);
   localparam logic [VEC_W-1:0] ONE   = {{(VEC_W-1){1'b0}}, 1'b1};
   localparam logic [VEC_W-1:0] VALID = ~ONE;

   logic [VEC_W-1:0] mask_keep;
   logic [VEC_W-1:0] ack_vec, force_hit, pend_ack, wr_clr, req_v;
   logic             test_d;

   // which mask bits are writable
   generate
      if (TOP_UNMASKABLE) begin : g_top_nmi
         assign mask_keep = VALID & ~(ONE << (VEC_W-1));
      end else begin : g_all_mask
         assign mask_keep = VALID;
      end
   endgenerate

   always_comb begin
      req_v     = req_i & VALID;
      ack_vec   = ack_i ? ((ONE << ack_level_i) & VALID) : '0;
      force_hit = test_q ? (ack_vec & force_q) : '0;
      pend_ack  = ack_vec & ~force_hit;
      wr_clr    = (wr_en_i && wr_sel_i == SEL_CLEAR) ? (wr_data_i & VALID) : '0;
      pend_d    = (pend_q & ~pend_ack & ~wr_clr) | req_v;
      mask_d    = (wr_en_i && wr_sel_i == SEL_MASK) ? (wr_data_i & mask_keep) : mask_q;
      force_d   = force_q & ~force_hit;
      if (wr_en_i && wr_sel_i == SEL_FORCE && test_q)
         force_d = wr_data_i & VALID;
      test_d    = (wr_en_i && wr_sel_i == SEL_CTRL) ? wr_data_i[0] : test_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         mask_q  <= '0;
         force_q <= '0;
         test_q  <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         mask_q  <= mask_d;
         force_q <= force_d;
         test_q  <= test_d;
      end
   end

   // R2 / R10: a request always lands in pending
   assert_req_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req_i & VALID)) |=> ((pend_q & $past(req_i & VALID)) == $past(req_i & VALID)));

   // R5: clear write with no competing request empties the written bits
   assert_clear_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == SEL_CLEAR && req_i == '0)
      |=> ((pend_q & $past(wr_data_i & VALID)) == '0));

   // R6 / R9: force contents hold while test mode is off
   assert_force_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !test_q |=> (force_q == $past(force_q)));
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
   parameter int NUM_LEVELS = 15,
   parameter int LVL_W      = 4
) (
   input  logic [NUM_LEVELS-1:0] vec_i,   // bit k = level k+1
   output logic [LVL_W-1:0]      lvl_o
);
   always_comb begin
      lvl_o = '0;
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (vec_i[i]) lvl_o = LVL_W'(i + 1);
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_LEVELS     = 15,
   parameter bit TOP_UNMASKABLE = 1'b1,
   localparam int VEC_W         = NUM_LEVELS + 1,
   localparam int LVL_W         = $clog2(VEC_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] req_i,
   input  logic             ack_i,
   input  logic [LVL_W-1:0] ack_level_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [VEC_W-1:0] wr_data_i,
   input  logic [1:0]       rd_sel_i,
   output logic [VEC_W-1:0] rd_data_o,
   output logic [LVL_W-1:0] irl_o
);
   generate
      if (NUM_LEVELS < 1 || NUM_LEVELS > 255) begin : g_bad_levels
         $error("irq_prio_ctrl: NUM_LEVELS out of range");
      end
      if ((1 << LVL_W) < VEC_W) begin : g_bad_width
         $error("irq_prio_ctrl: level width too narrow");
      end
   endgenerate

   logic [VEC_W-1:0] pend_q, mask_q, force_q, pend_d, mask_d, force_d;
   logic             test_q;
   logic [VEC_W-1:0] eff_d, eff_q;
   logic [LVL_W-1:0] lvl_d;

   irqc_level_regs #(
      .VEC_W(VEC_W), .LVL_W(LVL_W), .TOP_UNMASKABLE(TOP_UNMASKABLE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i),
      .ack_i(ack_i), .ack_level_i(ack_level_i),
      .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .pend_q(pend_q), .mask_q(mask_q), .force_q(force_q), .test_q(test_q),
      .pend_d(pend_d), .mask_d(mask_d), .force_d(force_d)
   );

   logic test_next;
   assign test_next = (wr_en_i && wr_sel_i == SEL_CTRL) ? wr_data_i[0] : test_q;

   // effective vector of the next state feeds the level register
   assign eff_d = (pend_d | (test_next ? force_d : '0)) & ~mask_d;
   // effective vector of the present state, used by the checks
   assign eff_q = (pend_q | (test_q ? force_q : '0)) & ~mask_q;

   irqc_prio_enc #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) enc_i (
      .vec_i(eff_d[VEC_W-1:1]), .lvl_o(lvl_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irl_o <= '0;
      else        irl_o <= lvl_d;
   end

   always_comb begin
      unique case (rd_sel_i)
         SEL_MASK:  rd_data_o = mask_q;
         SEL_CLEAR: rd_data_o = pend_q;
         SEL_FORCE: rd_data_o = force_q;
         default:   rd_data_o = {{(VEC_W-1){1'b0}}, test_q};
      endcase
   end

   // R3: level output is zero exactly when nothing is active
   assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((irl_o == '0) == (eff_q[VEC_W-1:1] == '0)));

   // R3: the reported level is active and nothing above it is
   assert_highest_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irl_o != '0) |-> (eff_q[irl_o] && ((eff_q >> irl_o) >> 1) == '0));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req_i = '0;
   logic        ack_i = 1'b0;
   logic [3:0]  ack_level_i = '0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_sel_i = '0;
   logic [15:0] wr_data_i = '0;
   logic [1:0]  rd_sel_i = '0;
   logic [15:0] rd_data_o;
   logic [3:0]  irl_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_prio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
      .ack_level_i(ack_level_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
      .irl_o(irl_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] sel, output logic [15:0] v);
      rd_sel_i = sel;
      #1;
      v = rd_data_o;
   endtask

   task automatic chk_reg(input string req, input logic [1:0] sel, input int exp);
      logic [15:0] v;
      rd(sel, v);
      check(req, int'(v), exp);
   endtask

   // each stimulus lives for one rising edge; results checked at next falling edge
   task automatic cyc();
      @(negedge clk);
      req_i = '0; ack_i = 1'b0; wr_en_i = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      cyc();
   endtask

   task automatic pulse(input logic [15:0] r);
      req_i = r;
      cyc();
   endtask

   task automatic ack(input logic [3:0] l);
      ack_i = 1'b1; ack_level_i = l;
      cyc();
   endtask

   task automatic t_reset();
      check("R1 irl", int'(irl_o), 0);
      chk_reg("R1 mask", 2'd0, 0);
      chk_reg("R1 pending", 2'd1, 0);
      chk_reg("R1 force", 2'd2, 0);
      chk_reg("R12 ctrl", 2'd3, 0);
   endtask

   task automatic t_request();
      pulse(16'h0021);
      check("R11 irl one cycle after request", int'(irl_o), 5);
      chk_reg("R2 pending, bit0 ignored", 2'd1, 16'h0020);
      pulse(16'h0204);
      check("R3 highest level", int'(irl_o), 9);
      chk_reg("R2 pending accumulates", 2'd1, 16'h0224);
   endtask

   task automatic t_mask();
      wr(2'd0, 16'hFFFF);
      chk_reg("R4 mask readback", 2'd0, 16'h7FFE);
      check("R3 all masked", int'(irl_o), 0);
      pulse(16'h8000);
      check("R4 level 15 unmaskable", int'(irl_o), 15);
      wr(2'd0, 16'h0200);
      check("R3 mask partial", int'(irl_o), 15);
   endtask

   task automatic t_clear();
      wr(2'd1, 16'h8200);
      chk_reg("R5 w1c pending", 2'd1, 16'h0024);
      check("R5 irl after clear", int'(irl_o), 5);
      wr(2'd0, 16'h0000);
      check("R3 unmask", int'(irl_o), 5);
      wr(2'd1, 16'hFFFF);
      chk_reg("R5 clear all", 2'd1, 0);
      check("R5 irl idle", int'(irl_o), 0);
   endtask

   task automatic t_force();
      wr(2'd2, 16'h0400);
      chk_reg("R6 force write ignored outside test", 2'd2, 0);
      check("R6 irl unchanged", int'(irl_o), 0);
      wr(2'd3, 16'h0001);
      chk_reg("R12 ctrl test on", 2'd3, 1);
      wr(2'd2, 16'h0401);
      chk_reg("R6 force stored, bit0 dropped", 2'd2, 16'h0400);
      check("R7 force drives level", int'(irl_o), 10);
      wr(2'd3, 16'h0000);
      check("R7 force ignored when test off", int'(irl_o), 0);
      chk_reg("R7 force retained", 2'd2, 16'h0400);
      wr(2'd3, 16'h0001);
      check("R7 force active again", int'(irl_o), 10);
   endtask

   task automatic t_ack_test();
      pulse(16'h0400);
      ack(4'd10);
      chk_reg("R8 force bit cleared first", 2'd2, 0);
      chk_reg("R8 pending kept", 2'd1, 16'h0400);
      check("R8 level still from pending", int'(irl_o), 10);
      ack(4'd10);
      chk_reg("R8 pending cleared", 2'd1, 0);
      check("R8 irl idle", int'(irl_o), 0);
   endtask

   task automatic t_ack_normal();
      wr(2'd2, 16'h0008);
      wr(2'd3, 16'h0000);
      pulse(16'h0008);
      check("R3 pending level 3", int'(irl_o), 3);
      ack(4'd3);
      chk_reg("R9 pending cleared", 2'd1, 0);
      chk_reg("R9 force untouched", 2'd2, 16'h0008);
      check("R9 irl idle", int'(irl_o), 0);
   endtask

   task automatic t_collide();
      pulse(16'h0040);
      req_i = 16'h0040; ack_i = 1'b1; ack_level_i = 4'd6;
      cyc();
      chk_reg("R10 request beats ack", 2'd1, 16'h0040);
      check("R10 irl", int'(irl_o), 6);
      req_i = 16'h0040; wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = 16'h0040;
      cyc();
      chk_reg("R10 request beats clear", 2'd1, 16'h0040);
      wr(2'd1, 16'h0040);
      check("R11 irl drops one cycle after clear", int'(irl_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_request();
      t_mask();
      t_clear();
      t_force();
      t_ack_test();
      t_ack_normal();
      t_collide();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule